// File: doc/BRIEF.md
# SPI Byte-Bus Master Controller

This block is an SPI master that software drives through a small byte-wide register bus. Seven byte registers hold the configuration (enables, clock polarity and phase, divider code), a status byte, a data port, a free parameter byte, chip-select control and a free timing byte. Writing the data port queues one byte in a four-entry transmit FIFO. When the core is enabled in master mode, the shift engine exchanges that byte full-duplex on `sclk`/`mosi`/`miso`, most significant bit first. It places the received byte in a four-entry receive FIFO, and reading the data port pops it.

The serial clock runs at the system clock divided by a power of two. The divisor is chosen by a 4-bit code split between two registers, and the code-to-divisor table is not monotonic. Four chip-select lines are driven by software, and each line has an enable bit and a level bit. An external fault input, which signals that another master is driving the bus, sets a fault flag, blocks new exchanges and can raise the interrupt line.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the registers read as follows: offset 0 (control) reads 0x51, offset 3 (extension) 0x00, offset 4 (parameter) 0x40, offset 6 (timing) 0x01, offset 5 (chip select) 0x00, and offset 1 (status) 0x09. At the same time `cs_n` is all ones, `irq` is 0 and `sclk` is 0.
- R2: Offsets 0, 3, 4, 5 and 6 read back the last byte written to them. Status bits are: 0 receive FIFO empty, 1 receive FIFO full, 2 transmit FIFO full, 3 transmit FIFO empty, 4 mode fault, 5 busy, 6 write collision, 7 interrupt flag.
- R3: A write to offset 2 starts an 8-bit full-duplex exchange, MSB first. Control bit 3 is CPOL and sets the idle `sclk` level. Control bit 2 is CPHA. With CPHA=0, `mosi` holds bit 7 before the first edge and each bit is sampled on leading edges. With CPHA=1, `mosi` changes on leading edges and is sampled on trailing edges.
- R4: The divider code is {offset3[1:0], control[1:0]}. Codes 0..11 give divisors 2, 4, 16, 32, 8, 64, 128, 256, 512, 1024, 2048 and 4096. Codes 12..15 give 4096. One `sclk` half period lasts divisor/2 clocks.
- R5: With half period h clocks, status bit 0 falls 16*h+2 clocks after the clock edge that accepts a data write into an idle, empty controller.
- R6: The transmit FIFO holds 4 bytes, and status bit 2 reports it full. A data write while it is full is dropped and sets status bit 6.
- R7: The receive FIFO holds 4 bytes, and reads of offset 2 pop them in arrival order. A read while it is empty returns 0 and changes nothing. No exchange starts while the receive FIFO is full.
- R8: In the chip-select register, bit n enables line n and bit n+4 is its level. `cs_n[n]` equals the level bit when the line is enabled and 1 otherwise. For example, 0x11<<n drives the line high and 0x01<<n drives it low.
- R9: When control bits 6 and 4 are both set and `fault_n` is low, status bit 4 sets. While it is set, no exchange starts.
- R10: Status bit 7 sets when each exchange completes. Writing 1 to status bits 7, 6 or 4 clears that bit. `irq` = control bit 7 AND (status bit 7 OR status bit 4).
- R11: While no exchange runs, `sclk` equals CPOL. Queued bytes wait while control bit 6 (enable) or bit 4 (master) is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops data port) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select lines |
| fault_n | input | 1 | Low when another master drives the bus |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are combinational, so the bench samples the status byte in the same cycle, one time unit after the falling edge. Register writes, chip-select levels, fault and collision flags and `irq` are due one clock after the accepting edge, and they are checked at the following falling edge. A received byte is due exactly 16*h+2 clocks after the data write. For each tested divider code, the bench checks that status bit 0 is still set at the falling edge after clock 16*h+1 and clear one clock later, which pins down the divisor and the engine latency together. A slave model samples `mosi` and updates `miso` on falling system-clock edges right after each detected `sclk` edge. It compares each captured byte with a queue the driver filled, and the receive path is compared with the bytes the slave was given.

// File: rtl/spi_bm_pkg.sv
// Package: shared constants, register offsets, engine states and the
// divider code decode for the SPI byte-bus master.
package spi_bm_pkg;
    localparam int BYTE_W  = 8;
    localparam int MAX_EXP = 12;            // largest divisor is 2**MAX_EXP
    localparam int HC_W    = MAX_EXP - 1;   // half-period counter width

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_STAT  = 3'd1,
        REG_DATA  = 3'd2,
        REG_EXT   = 3'd3,
        REG_PARAM = 3'd4,
        REG_CSEL  = 3'd5,
        REG_TIME  = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_DONE} eng_state_e;

    // Map a 4-bit divider code to log2 of the system-clock divisor.
    function automatic logic [3:0] div_exp(input logic [3:0] code);
        case (code)
            4'd0:    div_exp = 4'd1;
            4'd1:    div_exp = 4'd2;
            4'd2:    div_exp = 4'd4;
            4'd3:    div_exp = 4'd5;
            4'd4:    div_exp = 4'd3;
            default: div_exp = (code >= 4'd12) ? 4'(MAX_EXP) : code + 4'd1;
        endcase
    endfunction
endpackage

// File: rtl/spi_bm_fifo.sv
// Module: synchronous FIFO with a show-ahead head output.
// Assumes DEPTH is a power of two; push when full and pop when empty are
// ignored.
module spi_bm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   cnt;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (cnt == '0);
    assign full    = (cnt == (PW+1)'(DEPTH));
    assign dout    = mem[rd_ptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/spi_bm_engine.sv
// Module: one-byte full-duplex shift engine.
// Produces the sclk phase toggle (caller XORs in CPOL), drives mosi MSB
// first and assembles the received byte. Assumes cpha and half_m1 stay
// stable while busy. The done pulse comes one clock after the last edge.
module spi_bm_engine
    import spi_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              cpha,
    input  logic [HC_W-1:0]   half_m1,
    input  logic              miso,
    output logic              ph,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int EC_W = $clog2(2 * BYTE_W);
    localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(2 * BYTE_W - 1);

    eng_state_e        state;
    logic [HC_W-1:0]   hc;
    logic [EC_W-1:0]   ec;
    logic [BYTE_W-1:0] sr;

    assign busy = (state != ENG_IDLE);
    assign done = (state == ENG_DONE);

    // Sequence load, 16 sclk edges and the completion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ENG_IDLE;
            hc      <= '0;
            ec      <= '0;
            ph      <= 1'b0;
            sr      <= '0;
            rx_byte <= '0;
            mosi    <= 1'b0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    ph <= 1'b0;
                    if (start) begin
                        state <= ENG_RUN;
                        hc    <= '0;
                        ec    <= '0;
                        if (!cpha) begin
                            mosi <= tx_byte[BYTE_W-1];
                            sr   <= tx_byte << 1;
                        end else begin
                            sr   <= tx_byte;
                        end
                    end
                end
                ENG_RUN: begin
                    if (hc == half_m1) begin
                        hc <= '0;
                        ph <= ~ph;
                        ec <= ec + 1'b1;
                        if (ec[0] == cpha) begin
                            rx_byte <= {rx_byte[BYTE_W-2:0], miso};
                        end else begin
                            mosi <= sr[BYTE_W-1];
                            sr   <= sr << 1;
                        end
                        if (ec == LAST_EDGE) state <= ENG_DONE;
                    end else begin
                        hc <= hc + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_byte_master.sv
// Module: SPI master with a byte-wide register bus (top level).
// Holds the register file, status flags, both FIFOs, the divider decode
// and the chip-select drivers; the shift engine does the serial work.
// Assumes one bus access per cycle and synchronous active-low reset.
module spi_byte_master
    import spi_bm_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int NUM_CS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    input  logic              fault_n,
    output logic              irq
);
    logic [7:0] ctrl_q, ext_q, param_q, time_q, csel_q;
    logic       irqf_q, wcol_q, fault_q;

    logic [BYTE_W-1:0] tx_dout, rx_dout, rx_byte;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic tx_push, rx_pop, go, busy, done, ph;
    logic wr_data, wr_stat, fault_hit;

    logic [3:0]      div_code, exp_sel;
    logic [HC_W:0]   half_full;
    logic [HC_W-1:0] half_m1;

    assign wr_data   = bus_wr && (bus_addr == REG_DATA);
    assign wr_stat   = bus_wr && (bus_addr == REG_STAT);
    assign tx_push   = wr_data && !tx_full;
    assign rx_pop    = bus_rd && (bus_addr == REG_DATA);
    assign fault_hit = ctrl_q[6] && ctrl_q[4] && !fault_n;
    assign go        = !busy && !tx_empty && !rx_full && ctrl_q[6] && ctrl_q[4] && !fault_q;

    assign div_code  = {ext_q[1:0], ctrl_q[1:0]};
    assign exp_sel   = div_exp(div_code);
    assign half_full = (HC_W+1)'(1) << (exp_sel - 4'd1);
    assign half_m1   = HC_W'(half_full - 1'b1);

    assign sclk = ctrl_q[3] ^ ph;
    assign irq  = ctrl_q[7] && (irqf_q || fault_q);

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= 8'h51;
            ext_q   <= 8'h00;
            param_q <= 8'h40;
            time_q  <= 8'h01;
            csel_q  <= 8'h00;
        end else if (bus_wr) begin
            case (bus_addr)
                REG_CTRL:  ctrl_q  <= bus_wdata;
                REG_EXT:   ext_q   <= bus_wdata;
                REG_PARAM: param_q <= bus_wdata;
                REG_TIME:  time_q  <= bus_wdata;
                REG_CSEL:  csel_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Sticky status flags: set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irqf_q  <= 1'b0;
            wcol_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            if (done)                           irqf_q <= 1'b1;
            else if (wr_stat && bus_wdata[7])   irqf_q <= 1'b0;
            if (wr_data && tx_full)             wcol_q <= 1'b1;
            else if (wr_stat && bus_wdata[6])   wcol_q <= 1'b0;
            if (fault_hit)                      fault_q <= 1'b1;
            else if (wr_stat && bus_wdata[4])   fault_q <= 1'b0;
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (bus_addr)
            REG_CTRL:  bus_rdata = ctrl_q;
            REG_STAT:  bus_rdata = {irqf_q, wcol_q, busy, fault_q,
                                    tx_empty, tx_full, rx_full, rx_empty};
            REG_DATA:  bus_rdata = rx_empty ? 8'h00 : rx_dout;
            REG_EXT:   bus_rdata = ext_q;
            REG_PARAM: bus_rdata = param_q;
            REG_CSEL:  bus_rdata = csel_q;
            REG_TIME:  bus_rdata = time_q;
            default:   bus_rdata = 8'h00;
        endcase
    end

    // Chip-select drivers: enabled lines follow their level bit.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = csel_q[i] ? csel_q[i+4] : 1'b1;
    end

    spi_bm_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata),
        .pop(go), .dout(tx_dout), .empty(tx_empty), .full(tx_full)
    );

    spi_bm_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(done), .din(rx_byte),
        .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full)
    );

    spi_bm_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(go), .tx_byte(tx_dout),
        .cpha(ctrl_q[2]), .half_m1(half_m1), .miso(miso), .ph(ph),
        .mosi(mosi), .busy(busy), .done(done), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/spi_bm_chk.sv
// Module: property checker for spi_byte_master, attached with bind.
// Observes ports and internal handshakes; drives nothing.
module spi_bm_chk
    import spi_bm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic       sclk,
    input logic [7:0] ctrl_q,
    input logic       busy,
    input logic       tx_full,
    input logic       wcol,
    input logic       rx_full,
    input logic       rx_empty,
    input logic       done,
    input logic       fault_n,
    input logic       fault_q,
    input logic       irq
);
    // R11
    idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == ctrl_q[3]));

    // R6
    tx_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DATA && tx_full) |=> wcol);

    // R7
    rx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !busy) |=> !busy);

    // R5
    done_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !rx_empty);

    // R9
    fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[6] && ctrl_q[4] && !fault_n) |=> fault_q);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q[7]);
endmodule

bind spi_byte_master spi_bm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .sclk(sclk), .ctrl_q(ctrl_q), .busy(busy), .tx_full(tx_full),
    .wcol(wcol_q), .rx_full(rx_full), .rx_empty(rx_empty), .done(done),
    .fault_n(fault_n), .fault_q(fault_q), .irq(irq)
);

// File: tb/spi_byte_master_test.sv
// Bench: scoreboard for spi_byte_master. The driver queues expected bytes,
// a slave model on the serial pins compares what it captures, and data
// reads are compared against the bytes the slave sent.
module spi_byte_master_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sclk, mosi, miso = 1'b0, irq;
    logic [3:0] cs_n;
    logic       fault_n = 1'b1;

    int vectors = 0, miscompares = 0;
    logic [7:0] exp_mosi[$], slave_q[$], exp_rx[$];
    logic cpol_tb = 1'b0, cpha_tb = 1'b0, ie_tb = 1'b0;

    spi_byte_master uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
        .fault_n(fault_n), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek_stat(output logic [7:0] d);
        bus_addr = 3'd1;
        #1 d = bus_rdata;
    endtask

    // Driver: queue expectations, then write the byte.
    task automatic send(input logic [7:0] tx, input logic [7:0] resp);
        exp_mosi.push_back(tx);
        slave_q.push_back(resp);
        exp_rx.push_back(resp);
        reg_wr(3'd2, tx);
    endtask

    task automatic pop_check();
        logic [7:0] d, e;
        reg_rd(3'd2, d);
        e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'h00;
        chk("R3 R7 received byte", d, e);
    endtask

    // Send one byte and pin the receive-FIFO fill cycle (16*h+2).
    task automatic run_timed(input logic [7:0] tx, input logic [7:0] resp, input int h);
        logic [7:0] s;
        send(tx, resp);
        repeat (16 * h + 1) @(negedge clk);
        peek_stat(s);
        chk("R4 R5 still empty", {7'd0, s[0]}, 8'h01);
        @(negedge clk);
        peek_stat(s);
        chk("R4 R5 filled", {7'd0, s[0]}, 8'h00);
        pop_check();
    endtask

    task automatic set_mode(input logic cpol, input logic cpha, input logic [3:0] code);
        reg_wr(3'd5, 8'h11);
        reg_wr(3'd3, {6'd0, code[3:2]});
        reg_wr(3'd0, {ie_tb, 1'b1, 1'b0, 1'b1, cpol, cpha, code[1:0]});
        cpol_tb = cpol; cpha_tb = cpha;
        #1 chk("R11 idle sclk level", {7'd0, sclk}, {7'd0, cpol});
        reg_wr(3'd5, 8'h01);
    endtask

    // Slave model on chip select 0, evaluated on falling system-clock edges.
    logic       sl_prev = 1'b0, sl_loaded = 1'b0;
    logic [7:0] stx = 8'h00, srx = 8'h00;
    int         sl_ec = 0;
    always @(negedge clk) begin
        if (!rst_n || cs_n[0]) begin
            sl_prev = sclk;
        end else begin
            if (sclk !== sl_prev) begin
                logic lead;
                lead = (sclk != cpol_tb);
                if (lead != cpha_tb) begin
                    srx = {srx[6:0], mosi};
                end else begin
                    miso = stx[7];
                    stx  = stx << 1;
                end
                sl_ec++;
                if (sl_ec == 16) begin
                    sl_ec = 0;
                    sl_loaded = 1'b0;
                    if (exp_mosi.size() > 0) begin
                        chk("R3 mosi byte", srx, exp_mosi.pop_front());
                    end else begin
                        vectors++; miscompares++;
                        $display("FAIL R6: actual extra byte %h expected none", srx);
                    end
                end
            end
            if (!sl_loaded && sl_ec == 0 && slave_q.size() > 0) begin
                stx = slave_q.pop_front();
                sl_loaded = 1'b1;
                if (!cpha_tb) begin
                    miso = stx[7];
                    stx  = stx << 1;
                end
            end
            sl_prev = sclk;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 cs_n reset", {4'd0, cs_n}, 8'h0F);
        chk("R1 irq reset", {7'd0, irq}, 8'h00);
        chk("R1 sclk reset", {7'd0, sclk}, 8'h00);
        reg_rd(3'd0, d); chk("R1 control reset", d, 8'h51);
        reg_rd(3'd1, d); chk("R1 status reset", d, 8'h09);
        reg_rd(3'd3, d); chk("R1 extension reset", d, 8'h00);
        reg_rd(3'd4, d); chk("R1 parameter reset", d, 8'h40);
        reg_rd(3'd5, d); chk("R1 chip select reset", d, 8'h00);
        reg_rd(3'd6, d); chk("R1 timing reset", d, 8'h01);

        reg_wr(3'd4, 8'hA5); reg_rd(3'd4, d); chk("R2 parameter readback", d, 8'hA5);
        reg_wr(3'd6, 8'h3C); reg_rd(3'd6, d); chk("R2 timing readback", d, 8'h3C);

        // R7: empty read returns 0 and leaves status alone
        reg_rd(3'd2, d); chk("R7 empty read", d, 8'h00);
        peek_stat(d);    chk("R7 empty read status", d, 8'h09);

        // R3 R4 R5 across modes and divider codes
        set_mode(1'b0, 1'b0, 4'd0);
        #1 chk("R8 cs0 active", {4'd0, cs_n}, 8'h0E);
        run_timed(8'hA5, 8'h3C, 1);
        set_mode(1'b0, 1'b1, 4'd1);
        run_timed(8'h81, 8'h7E, 2);
        set_mode(1'b1, 1'b0, 4'd4);
        run_timed(8'h5B, 8'hC6, 4);
        set_mode(1'b1, 1'b1, 4'd2);
        run_timed(8'h0F, 8'hF0, 8);
        set_mode(1'b0, 1'b1, 4'd5);
        run_timed(8'h96, 8'h69, 32);
        set_mode(1'b0, 1'b0, 4'd0);

        // R6 R11: core disabled, fill the transmit FIFO, then collide
        reg_wr(3'd0, 8'h10);
        send(8'h11, 8'h22); send(8'h33, 8'h44); send(8'h55, 8'h66); send(8'h77, 8'h88);
        repeat (10) @(negedge clk);
        peek_stat(d);
        chk("R11 disabled holds bytes", d & 8'h2C, 8'h04);
        chk("R6 tx full flag", {7'd0, d[2]}, 8'h01);
        reg_wr(3'd2, 8'hEE);
        peek_stat(d);
        chk("R6 collision flag", {7'd0, d[6]}, 8'h01);
        reg_wr(3'd1, 8'h40);
        peek_stat(d);
        chk("R10 collision cleared", {7'd0, d[6]}, 8'h00);
        reg_wr(3'd0, 8'h50);
        repeat (150) @(negedge clk);
        peek_stat(d);
        chk("R7 rx full after four", d & 8'h2B, 8'h0A);

        // R7: no start while receive FIFO is full
        send(8'h5A, 8'hC3);
        repeat (60) @(negedge clk);
        peek_stat(d);
        chk("R7 stall while rx full", d & 8'h28, 8'h00);
        pop_check();
        repeat (60) @(negedge clk);
        pop_check(); pop_check(); pop_check(); pop_check();
        peek_stat(d);
        chk("R7 drained", d & 8'h0B, 8'h09);

        // R10: interrupt flag and its gate
        chk("R10 flag set", {7'd0, d[7]}, 8'h01);
        chk("R10 irq gated off", {7'd0, irq}, 8'h00);
        ie_tb = 1'b1;
        reg_wr(3'd0, 8'hD0);
        chk("R10 irq on", {7'd0, irq}, 8'h01);
        reg_wr(3'd1, 8'h80);
        peek_stat(d);
        chk("R10 flag cleared", {7'd0, d[7]}, 8'h00);
        chk("R10 irq off", {7'd0, irq}, 8'h00);

        // R9: mode fault blocks and interrupts
        @(negedge clk); fault_n = 1'b0;
        @(negedge clk); fault_n = 1'b1;
        peek_stat(d);
        chk("R9 fault flag", {7'd0, d[4]}, 8'h01);
        chk("R9 fault irq", {7'd0, irq}, 8'h01);
        send(8'hC5, 8'h5C);
        repeat (60) @(negedge clk);
        peek_stat(d);
        chk("R9 fault blocks start", d & 8'h29, 8'h01);
        reg_wr(3'd1, 8'h10);
        repeat (40) @(negedge clk);
        pop_check();
        peek_stat(d);
        chk("R9 fault cleared", {7'd0, d[4]}, 8'h00);
        reg_wr(3'd1, 8'h80);

        // R8: chip-select enable/level pairs
        reg_wr(3'd5, 8'h22); chk("R8 cs1 driven high", {4'd0, cs_n}, 8'h0F);
        reg_wr(3'd5, 8'h02); chk("R8 cs1 driven low", {4'd0, cs_n}, 8'h0D);
        reg_wr(3'd5, 8'h08); chk("R8 cs3 driven low", {4'd0, cs_n}, 8'h07);
        reg_wr(3'd5, 8'h80); chk("R8 level without enable", {4'd0, cs_n}, 8'h0F);
        reg_rd(3'd5, d);     chk("R2 chip select readback", d, 8'h80);

        chk("R3 all bytes seen", 8'(exp_mosi.size()), 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule